// File: doc/BRIEF.md
# Serial Loopback Framer with Shared CRC-32

This block turns a programmed number of payload bytes into a serial frame, one bit per clock, and receives the same frame again when the line is looped back. Each frame begins with a 56-bit alternating training pattern and an 8-bit start marker. The payload bytes follow, least significant bit first. The block is meant for self-test of a transmit and receive path. Software or a test sequencer starts a frame and then compares what comes back.

A single CRC-32 engine is shared between the two directions, and the per-frame `inhibit_crc` control decides which direction owns it. With the control low, the transmitter runs the engine over the payload and appends the complemented remainder as four bytes; the receiver passes every byte out unchecked. With the control high, no CRC is appended. The receiver then runs the engine over everything after the start marker, and at the end of reception it reports whether the fixed CRC-32 residue is present. That only happens when the payload already ends in a correct CRC.

Payload enters on a valid/ready stream. `src_ready` is high for exactly one cycle at each point where the framer needs the next byte. A byte moves on a cycle where both `src_valid` and `src_ready` are high. The source may raise `src_valid` at any time, but it must hold it high whenever `src_ready` is high, because the serial line cannot pause. Received bytes leave on `rx_valid`/`rx_data` with no back-pressure, since the looped line cannot be held either.

Top module: `loopback_framer`

## Requirements
- R1: In the cycle after an accepted `start`, `tx_bit` carries 56 alternating bits beginning with 1. These are followed by the marker byte 0xAB sent least significant bit first (bits 1,1,0,1,0,1,0,1), one bit per clock.
- R2: Exactly `byte_count` payload bytes are taken from the source. Each transfer is a cycle with `src_valid` and `src_ready` both high. Each byte is sent least significant bit first, directly after the marker or after the previous byte.
- R3: With `inhibit_crc` low, four bytes follow the payload. They hold the complement of the reflected CRC-32 (polynomial 0x04C11DB7, register preset to all ones) computed over the payload, lowest byte first.
- R4: With `inhibit_crc` high, no CRC bytes are appended, and `busy` lasts 64 + 8·`byte_count` cycles.
- R5: `busy` rises in the cycle after an accepted `start`. It stays high until the last bit has been sent: 64 + 8·`byte_count` + 32 cycles when a CRC is appended.
- R6: On the receive side, after the 0xAB marker is seen on `rx_bit` while `rx_en` is high, every further 8 bits produce one `rx_valid` pulse. `rx_data` carries that byte, assembled least significant bit first.
- R7: When `rx_en` falls after a marker, `rx_done` pulses for one cycle. In inhibit mode, `crc_ok` then goes high if the receive CRC register holds the residue whose bit-reversed value is 0xC704DD7B. It keeps that value until the next accepted `start`.
- R8: With `inhibit_crc` low, `crc_ok` stays low, because the receiver does not check the CRC.
- R9: `start` is ignored while `busy` is high.
- R10: A `byte_count` of zero sends no payload. It still appends the CRC of the empty payload (four zero bytes) when not inhibited.
- R11: `byte_count` and `inhibit_crc` are sampled only when a `start` is accepted. Changes during a frame do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame (accepted only while idle) |
| byte_count | input | CNT_W | Payload byte count, sampled at start |
| inhibit_crc | input | 1 | 1: no CRC appended, receiver checks; 0: CRC appended, no check |
| src_valid | input | 1 | Payload byte available |
| src_ready | output | 1 | Framer takes a byte this cycle |
| src_data | input | 8 | Payload byte |
| tx_bit | output | 1 | Serial transmit data |
| busy | output | 1 | Frame being transmitted |
| rx_en | input | 1 | Looped-back line active |
| rx_bit | input | 1 | Looped-back serial data |
| rx_valid | output | 1 | Received byte strobe |
| rx_data | output | 8 | Received byte |
| rx_done | output | 1 | End-of-reception pulse |
| crc_ok | output | 1 | Receive CRC residue matched (inhibit mode only) |

## Verification
The assertions take for granted that the source never leaves `src_valid` low in a cycle where `src_ready` is high. They also assume that a looped frame finishes arriving before the next `start`, so the engine's owner does not change during reception. The stimulus drives `src_valid` high in every ready cycle and randomises it in all other cycles. It ties `rx_bit` and `rx_en` straight to `tx_bit` and `busy`, and waits for `rx_done` before launching the next frame.

// File: rtl/loopback_pkg.sv
package loopback_pkg;
  localparam logic [7:0]  SFD_BYTE  = 8'hAB;
  localparam logic [31:0] POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] RESIDUE   = 32'hC704DD7B;
  localparam int          PRE_BITS  = 56;

  typedef enum logic [2:0] {
    TX_IDLE, TX_PRE, TX_SFD, TX_DATA, TX_FCS
  } tx_state_t;

  function automatic logic [31:0] bit_rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction
endpackage

// File: rtl/crc32_serial.sv
module crc32_serial
  import loopback_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic        din,
  output logic [31:0] q
);
  logic fb;
  assign fb = q[0] ^ din;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) q <= '1;
    else if (en)       q <= (q >> 1) ^ (fb ? POLY_REFL : 32'h0);
  end

  // R3: a cleared engine starts from the all-ones preset
  a_r3_preset: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> q == 32'hFFFFFFFF);
endmodule

// File: rtl/lb_tx.sv
module lb_tx
  import loopback_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             inhibit_crc,
  input  logic             src_valid,
  output logic             src_ready,
  input  logic [7:0]       src_data,
  input  logic [31:0]      crc_q,
  output logic             crc_en,
  output logic             crc_bit,
  output logic             launch,
  output logic             chk_mode,
  output logic             tx_bit,
  output logic             busy
);
  localparam int BC_W = $clog2(PRE_BITS);

  tx_state_t        state;
  logic [BC_W-1:0]  bitcnt;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       sh;
  logic             byte_end;

  assign launch    = start && (state == TX_IDLE);
  assign busy      = (state != TX_IDLE);
  assign byte_end  = (state == TX_SFD || state == TX_DATA) && bitcnt == BC_W'(7);
  assign src_ready = byte_end && (cnt != '0);
  assign crc_en    = !chk_mode && (state == TX_DATA);
  assign crc_bit   = sh[0];

  always_comb begin
    unique case (state)
      TX_PRE:  tx_bit = ~bitcnt[0];
      TX_SFD:  tx_bit = SFD_BYTE[bitcnt[2:0]];
      TX_DATA: tx_bit = sh[0];
      TX_FCS:  tx_bit = ~crc_q[bitcnt[4:0]];
      default: tx_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= TX_IDLE;
      bitcnt   <= '0;
      cnt      <= '0;
      sh       <= '0;
      chk_mode <= 1'b0;
    end else begin
      unique case (state)
        TX_IDLE: if (start) begin
          state    <= TX_PRE;
          bitcnt   <= '0;
          cnt      <= byte_count;
          chk_mode <= inhibit_crc;
        end
        TX_PRE: begin
          if (bitcnt == BC_W'(PRE_BITS-1)) begin
            state  <= TX_SFD;
            bitcnt <= '0;
          end else bitcnt <= bitcnt + 1'b1;
        end
        TX_SFD, TX_DATA: begin
          sh <= sh >> 1;
          if (!byte_end) bitcnt <= bitcnt + 1'b1;
          else begin
            bitcnt <= '0;
            if (cnt != '0) begin
              sh    <= src_data;
              cnt   <= cnt - 1'b1;
              state <= TX_DATA;
            end else begin
              state <= chk_mode ? TX_IDLE : TX_FCS;
            end
          end
        end
        TX_FCS: begin
          if (bitcnt == BC_W'(31)) state <= TX_IDLE;
          else bitcnt <= bitcnt + 1'b1;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  // R1: training bits alternate
  a_r1_pre_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_PRE && $past(state) == TX_PRE) |-> tx_bit != $past(tx_bit));
  // R2: the source keeps data available whenever a byte is requested
  a_r2_src_supplied: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> src_valid);
  // R2: bytes are only requested inside a frame
  a_r2_ready_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> busy);
  // R11: the frame's mode does not change while it is sent
  a_r11_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(chk_mode));
endmodule

// File: rtl/lb_rx.sv
module lb_rx
  import loopback_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_en,
  input  logic        rx_bit,
  input  logic        chk_mode,
  input  logic        launch,
  input  logic [31:0] crc_q,
  output logic        crc_en,
  output logic        rx_valid,
  output logic [7:0]  rx_data,
  output logic        rx_done,
  output logic        crc_ok
);
  logic       in_pay;
  logic [7:0] hunt;
  logic [7:0] sr;
  logic [2:0] bcnt;
  logic [7:0] hunt_nx;
  logic [7:0] sr_nx;

  assign hunt_nx = {rx_bit, hunt[7:1]};
  assign sr_nx   = {rx_bit, sr[7:1]};
  assign crc_en  = in_pay && rx_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pay   <= 1'b0;
      hunt     <= '0;
      sr       <= '0;
      bcnt     <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_done  <= 1'b0;
      crc_ok   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rx_done  <= 1'b0;
      if (launch) crc_ok <= 1'b0;
      if (!in_pay) begin
        if (rx_en) begin
          hunt <= hunt_nx;
          if (hunt_nx == SFD_BYTE) begin
            in_pay <= 1'b1;
            bcnt   <= '0;
          end
        end else hunt <= '0;
      end else if (rx_en) begin
        sr   <= sr_nx;
        bcnt <= bcnt + 1'b1;
        if (bcnt == 3'd7) begin
          rx_valid <= 1'b1;
          rx_data  <= sr_nx;
        end
      end else begin
        in_pay  <= 1'b0;
        hunt    <= '0;
        rx_done <= 1'b1;
        crc_ok  <= chk_mode && (bit_rev32(crc_q) == RESIDUE);
      end
    end
  end

  // R6: bytes come out only from an active line
  a_r6_valid_from_line: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rx_en));
  // R7: end-of-reception is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);
  // R8: a passing check only exists for frames the receiver checked
  a_r8_ok_needs_check: assert property (@(posedge clk) disable iff (!rst_n)
    crc_ok |-> chk_mode);
endmodule

// File: rtl/loopback_framer.sv
module loopback_framer
  import loopback_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             inhibit_crc,
  input  logic             src_valid,
  output logic             src_ready,
  input  logic [7:0]       src_data,
  output logic             tx_bit,
  output logic             busy,
  input  logic             rx_en,
  input  logic             rx_bit,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             rx_done,
  output logic             crc_ok
);
  logic [31:0] crc_q;
  logic        tx_crc_en, tx_crc_bit, rx_crc_en;
  logic        launch, chk_mode;
  logic        crc_en, crc_din;

  // One engine: the per-frame mode decides which side drives it
  assign crc_en  = chk_mode ? rx_crc_en : tx_crc_en;
  assign crc_din = chk_mode ? rx_bit    : tx_crc_bit;

  crc32_serial u_crc (
    .clk(clk), .rst_n(rst_n), .clr(launch), .en(crc_en), .din(crc_din), .q(crc_q)
  );

  lb_tx #(.CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .inhibit_crc(inhibit_crc), .src_valid(src_valid), .src_ready(src_ready),
    .src_data(src_data), .crc_q(crc_q), .crc_en(tx_crc_en), .crc_bit(tx_crc_bit),
    .launch(launch), .chk_mode(chk_mode), .tx_bit(tx_bit), .busy(busy)
  );

  lb_rx u_rx (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_bit(rx_bit), .chk_mode(chk_mode),
    .launch(launch), .crc_q(crc_q), .crc_en(rx_crc_en), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_done(rx_done), .crc_ok(crc_ok)
  );

  // R9: a start during a frame does not restart it
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |-> !launch);
endmodule

// File: tb/loopback_framer_test.sv
module loopback_framer_test;
  localparam int CNT_W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] byte_count = '0;
  logic inhibit_crc = 1'b0;
  logic src_valid = 1'b0;
  logic src_ready;
  logic [7:0] src_data = '0;
  logic tx_bit, busy, rx_valid, rx_done, crc_ok;
  logic [7:0] rx_data;

  int errors = 0;
  int checks = 0;

  byte unsigned pay [0:63];
  byte unsigned expb[0:63];
  byte unsigned got [0:63];

  always #2.5 clk = ~clk;

  loopback_framer #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .inhibit_crc(inhibit_crc), .src_valid(src_valid), .src_ready(src_ready),
    .src_data(src_data), .tx_bit(tx_bit), .busy(busy), .rx_en(busy), .rx_bit(tx_bit),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_done(rx_done), .crc_ok(crc_ok)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ b[i]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  function automatic logic [31:0] crc_of(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) c = crc_byte(c, pay[i]);
    return c;
  endfunction

  function automatic bit pre_bit(input int i);
    logic [7:0] sfd = 8'hAB;
    if (i < 56) return (i % 2 == 0);
    return sfd[i-56];
  endfunction

  // n: bytes programmed; inh: inhibit; disturb: toggle start/mode mid-frame
  task automatic run_frame(input int n, input bit inh, input bit disturb);
    int idx = 0, g = 0, bcyc = 0, cyc = 0, m, pre_err = 0;
    bit done = 0, ok_exp;
    logic [31:0] fcs;
    m = n;
    for (int i = 0; i < n; i++) expb[i] = pay[i];
    if (!inh) begin
      fcs = ~crc_of(n);
      for (int i = 0; i < 4; i++) expb[n+i] = fcs[8*i +: 8];
      m = n + 4;
    end
    ok_exp = inh && (crc_of(n) == 32'hDEBB20E3);
    @(negedge clk);
    start = 1'b1; byte_count = CNT_W'(n); inhibit_crc = inh;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 2000) begin
      if (busy) begin
        if (bcyc < 64 && tx_bit != pre_bit(bcyc)) pre_err++;
        bcyc++;
      end
      src_valid = src_ready ? 1'b1 : 1'($urandom % 2);
      src_data  = pay[idx];
      if (src_ready) idx++;
      if (rx_valid && g < 64) begin got[g] = rx_data; g++; end
      if (rx_done) done = 1;
      if (disturb && cyc == 20) begin
        start = 1'b1; inhibit_crc = ~inh; byte_count = CNT_W'(5);
      end else if (disturb && cyc == 21) start = 1'b0;
      cyc++;
      if (!done) @(negedge clk);
    end
    check(done, "R7 rx_done seen", done, 1);
    check(pre_err == 0, "R1 training and marker bits", pre_err, 0);
    check(bcyc == 64 + 8*n + (inh ? 0 : 32), inh ? "R4 busy length" : "R5 busy length",
          bcyc, 64 + 8*n + (inh ? 0 : 32));
    check(idx == n, "R2 bytes taken", idx, n);
    check(g == m, "R6 bytes received", g, m);
    for (int i = 0; i < m && i < g; i++)
      check(got[i] == expb[i], inh ? "R6 rx byte" : "R3 rx byte incl CRC", got[i], expb[i]);
    check(crc_ok == ok_exp, inh ? "R7 crc_ok" : "R8 crc_ok low", crc_ok, ok_exp);
    repeat (3) @(negedge clk);
    check(crc_ok == ok_exp, "R7 crc_ok held", crc_ok, ok_exp);
    check(!busy, "R9 idle after frame", busy, 0);
  endtask

  task automatic fill_rand(input int n);
    for (int i = 0; i < n; i++) pay[i] = 8'($urandom);
  endtask

  task automatic fill_with_crc(input int k);
    logic [31:0] f;
    fill_rand(k);
    f = ~crc_of(k);
    for (int i = 0; i < 4; i++) pay[k+i] = f[8*i +: 8];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !src_ready && !crc_ok && !rx_valid && !rx_done, "R5 reset state",
          {busy, src_ready, crc_ok, rx_valid, rx_done}, 0);
    // R3, R5: CRC generation, several lengths
    fill_rand(1);  run_frame(1, 0, 0);
    fill_rand(13); run_frame(13, 0, 0);
    for (int t = 0; t < 4; t++) begin
      int n = 2 + int'($urandom % 30);
      fill_rand(n); run_frame(n, 0, 0);
    end
    // R10: empty payload in both modes
    run_frame(0, 0, 0);
    run_frame(0, 1, 0);
    // R7: receiver check with a correct trailing CRC
    fill_with_crc(0);  run_frame(4, 1, 0);
    fill_with_crc(9);  run_frame(13, 1, 0);
    for (int t = 0; t < 3; t++) begin
      int k = 1 + int'($urandom % 30);
      fill_with_crc(k); run_frame(k + 4, 1, 0);
    end
    // R7: corrupted frame must fail the check
    fill_with_crc(12); pay[5] = pay[5] ^ 8'h10; run_frame(16, 1, 0);
    // R4: inhibit with arbitrary payload (no CRC)
    fill_rand(3); run_frame(3, 1, 0);
    // R9, R11: start and mode changes mid-frame are ignored
    fill_rand(10); run_frame(10, 0, 1);
    fill_with_crc(6); run_frame(10, 1, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule